// File: doc/BRIEF.md
# Vector Even/Odd Widening Multiplier

This unit multiplies two 128-bit source vectors lane by lane and returns a product vector whose elements are twice as wide as the source elements. Only half of the source lanes take part in one operation: either the even-numbered lanes or the odd-numbered ones. Lanes are counted big-endian, so lane 0 sits in the most significant bits. Issuing the even form and the odd form on the same operands yields every product of the two vectors.

A 3-bit control word is sampled with the operands. It selects even or odd lanes, signed or unsigned operands, and 16-bit or 8-bit elements. Halfword mode gives four 32-bit products. Byte mode gives eight 16-bit products. The products are exact, with no saturation, no flags and no exceptions. Operands are captured at issue, so the source registers may be overwritten, or reused as the destination, while the operation is in flight. The unit accepts one operation per clock once it is out of reset. Each result appears a fixed two clocks after it is accepted.

Top module: `vec_widen_mul`

## Requirements
- R1: In even halfword mode (ctrl = 3'b000 signed, 3'b010 unsigned), result word i (bits [127-32i -: 32]) is the product of halfword lane 2i of A and halfword lane 2i of B, for i = 0..3. Halfword lane k occupies bits [127-16k -: 16]. A zero operand gives a zero product.
- R2: In odd halfword mode (ctrl bit 2 = 1), result word i uses halfword lane 2i+1 of each source instead.
- R3: With ctrl bit 1 = 0 the operands are signed 16-bit values and the product is a full 32-bit two's-complement value with no saturation. For example, 0x8000 * 0x8000 gives 0x40000000 and 0x7FFF * 0x8000 gives 0xC0008000.
- R4: With ctrl bit 1 = 1 the operands are unsigned, so 0xFFFF * 0xFFFF gives 0xFFFE0001.
- R5: With ctrl bit 0 = 1 (byte mode), result halfword i (bits [127-16i -: 16]) is the product of byte lane 2i+odd of A and of B, for i = 0..7. Byte lane k occupies bits [127-8k -: 8]. Signed and unsigned forms both apply, for example signed 0x80 * 0x80 = 0x4000 and unsigned 0xFF * 0xFF = 0xFE01.
- R6: Source lanes that the mode does not select have no effect on the result.
- R7: out_valid rises exactly two clock edges after an accepted issue (in_valid and in_ready both high at an edge). There is exactly one result for each accepted issue, and results come out in issue order.
- R8: A result depends only on the operands and control present at the accepting edge. Later changes to the inputs do not alter it.
- R9: While rst_n is low at a clock edge, the pipeline empties. After that edge out_valid and in_ready are low, and in_valid is ignored.
- R10: From the second edge after rst_n goes high, in_ready stays high, and a new operation is accepted on every edge with in_valid high.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| in_ready | output | 1 | Unit can accept an operation |
| op_ctrl | input | 3 | {odd, unsigned, byte} mode select |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | out_result holds a finished product vector |
| out_result | output | 128 | Widened product vector |

## Verification
The no-overflow and zero-product assertions assume that the captured operands came from a real issue. They therefore check only on cycles when the first stage advanced. The stimulus keeps every lane at a true 16-bit or 8-bit value, so the sign-extension bit always matches the element's top bit. The latency property assumes that in_valid is never X around an accepting edge. The bench therefore drives in_valid to a known level from time zero, including during reset. It also fills the operand buses with random data on idle cycles, so that any dependence on later inputs would show.

// File: rtl/vwm_pkg.sv
// Package: shared defaults and the control-word layout for the widening multiplier.
// Assumes: control bit 2 = odd lanes, bit 1 = unsigned, bit 0 = byte elements.
package vwm_pkg;
    localparam int VEC_W_DEF  = 128;
    localparam int HALF_W_DEF = 16;
    localparam int BYTE_W_DEF = 8;

    typedef struct packed {
        logic odd;
        logic is_unsigned;
        logic is_byte;
    } vwm_ctrl_t;
endpackage

// File: rtl/vwm_operand_pick.sv
// Module: selects the even or odd source lanes and extends each one by one bit,
// either with its sign or with zero, so that one signed multiplier serves both forms.
// Assumes: VEC_W is a multiple of 2*HALF_W, and HALF_W = 2*BYTE_W. Lanes are big-endian.
module vwm_operand_pick
    import vwm_pkg::*;
#(
    parameter int VEC_W  = VEC_W_DEF,
    parameter int HALF_W = HALF_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int HSLOTS = VEC_W / (2 * HALF_W),
    localparam int SLOTS  = VEC_W / (2 * BYTE_W),
    localparam int LSLOTS = SLOTS - HSLOTS,
    localparam int HEXT   = HALF_W + 1,
    localparam int BEXT   = BYTE_W + 1
) (
    input  vwm_ctrl_t                        ctrl,
    input  logic [VEC_W-1:0]                 src_a,
    input  logic [VEC_W-1:0]                 src_b,
    output logic [HSLOTS-1:0][HEXT-1:0]      hi_a,
    output logic [HSLOTS-1:0][HEXT-1:0]      hi_b,
    output logic [LSLOTS-1:0][BEXT-1:0]      lo_a,
    output logic [LSLOTS-1:0][BEXT-1:0]      lo_b
);
    // Slots that serve halfword products, and byte products in byte mode.
    for (genvar g = 0; g < HSLOTS; g++) begin : g_hi
        localparam int HTOP = VEC_W - 1 - 2 * HALF_W * g;
        localparam int BTOP = VEC_W - 1 - 2 * BYTE_W * g;
        logic [HALF_W-1:0] ha, hb;
        logic [BYTE_W-1:0] ba, bb;
        logic              sa_h, sb_h, sa_b, sb_b;

        // Purpose: pick the lane of each size and extend whichever one the mode asks for.
        always_comb begin
            ha   = ctrl.odd ? src_a[HTOP-HALF_W -: HALF_W] : src_a[HTOP -: HALF_W];
            hb   = ctrl.odd ? src_b[HTOP-HALF_W -: HALF_W] : src_b[HTOP -: HALF_W];
            ba   = ctrl.odd ? src_a[BTOP-BYTE_W -: BYTE_W] : src_a[BTOP -: BYTE_W];
            bb   = ctrl.odd ? src_b[BTOP-BYTE_W -: BYTE_W] : src_b[BTOP -: BYTE_W];
            sa_h = ~ctrl.is_unsigned & ha[HALF_W-1];
            sb_h = ~ctrl.is_unsigned & hb[HALF_W-1];
            sa_b = ~ctrl.is_unsigned & ba[BYTE_W-1];
            sb_b = ~ctrl.is_unsigned & bb[BYTE_W-1];
            if (ctrl.is_byte) begin
                hi_a[g] = {{(HEXT-BYTE_W){sa_b}}, ba};
                hi_b[g] = {{(HEXT-BYTE_W){sb_b}}, bb};
            end else begin
                hi_a[g] = {sa_h, ha};
                hi_b[g] = {sb_h, hb};
            end
        end
    end

    // Slots that serve only byte products.
    for (genvar g = 0; g < LSLOTS; g++) begin : g_lo
        localparam int BTOP = VEC_W - 1 - 2 * BYTE_W * (g + HSLOTS);
        logic [BYTE_W-1:0] ba, bb;

        // Purpose: pick the selected byte lane of each source and extend it.
        always_comb begin
            ba      = ctrl.odd ? src_a[BTOP-BYTE_W -: BYTE_W] : src_a[BTOP -: BYTE_W];
            bb      = ctrl.odd ? src_b[BTOP-BYTE_W -: BYTE_W] : src_b[BTOP -: BYTE_W];
            lo_a[g] = {~ctrl.is_unsigned & ba[BYTE_W-1], ba};
            lo_b[g] = {~ctrl.is_unsigned & bb[BYTE_W-1], bb};
        end
    end
endmodule

// File: rtl/vwm_lane_mult.sv
// Module: one signed multiplier slot with a registered product.
// Assumes: the operands are already extended, so the product of two OP_W-bit signed
// values fits in 2*(OP_W-1) bits. The register loads only when adv is high.
module vwm_lane_mult #(
    parameter int OP_W = 17,
    localparam int PW  = 2 * (OP_W - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic [PW-1:0]   prod_q
);
    logic signed [OP_W-1:0] sa, sb;
    logic signed [PW-1:0]   prod_c;

    // Purpose: form the exact product at the output width.
    always_comb begin
        sa     = op_a;
        sb     = op_b;
        prod_c = PW'(sa) * PW'(sb);
    end

    // Purpose: hold the product for the output stage.
    always_ff @(posedge clk) begin
        if (adv) prod_q <= prod_c;
    end

    // R3: operands of the same sign that both fit the element range give a positive product.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && $past(op_a) != '0 && $past(op_b) != '0 &&
         $past(op_a[OP_W-1]) == $past(op_a[OP_W-2]) &&
         $past(op_b[OP_W-1]) == $past(op_b[OP_W-2]) &&
         $past(op_a[OP_W-1]) == $past(op_b[OP_W-1]))
        |-> (!prod_q[PW-1] && prod_q != '0));

    // R1: a zero operand yields a zero product.
    assert_zero_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> (prod_q == '0));
endmodule

// File: rtl/vwm_result_pack.sv
// Module: places the slot products into the result vector for the mode in force.
// Assumes: the hi slots give the halfword products (word i = slot i). In byte mode
// halfword i comes from slot i, where the hi slots come first and the lo slots follow.
module vwm_result_pack #(
    parameter int VEC_W  = 128,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8,
    localparam int HSLOTS = VEC_W / (2 * HALF_W),
    localparam int SLOTS  = VEC_W / (2 * BYTE_W),
    localparam int LSLOTS = SLOTS - HSLOTS
) (
    input  logic                              is_byte,
    input  logic [HSLOTS-1:0][2*HALF_W-1:0]   hi_p,
    input  logic [LSLOTS-1:0][2*BYTE_W-1:0]   lo_p,
    output logic [VEC_W-1:0]                  result
);
    // Purpose: route each product to its big-endian element position.
    always_comb begin
        result = '0;
        if (is_byte) begin
            for (int g = 0; g < HSLOTS; g++)
                result[VEC_W-1-2*BYTE_W*g -: 2*BYTE_W] = hi_p[g][2*BYTE_W-1:0];
            for (int g = 0; g < LSLOTS; g++)
                result[VEC_W-1-2*BYTE_W*(g+HSLOTS) -: 2*BYTE_W] = lo_p[g];
        end else begin
            for (int g = 0; g < HSLOTS; g++)
                result[VEC_W-1-2*HALF_W*g -: 2*HALF_W] = hi_p[g];
        end
    end
endmodule

// File: rtl/vec_widen_mul.sv
// Module: top of the even/odd widening multiplier. It picks lanes and captures the
// extended operands at issue (stage 1), registers the products (stage 2), then packs them.
// Assumes: the output is never stalled, so in_ready depends only on reset.
module vec_widen_mul
    import vwm_pkg::*;
#(
    parameter int VEC_W  = VEC_W_DEF,
    parameter int HALF_W = HALF_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int HSLOTS = VEC_W / (2 * HALF_W),
    localparam int SLOTS  = VEC_W / (2 * BYTE_W),
    localparam int LSLOTS = SLOTS - HSLOTS,
    localparam int HEXT   = HALF_W + 1,
    localparam int BEXT   = BYTE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       op_ctrl,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result
);
    vwm_ctrl_t ctrl;
    logic      ready_q, fire;
    logic      v1_q, v2_q, byte1_q, byte2_q;

    logic [HSLOTS-1:0][HEXT-1:0]     hi_a, hi_b, hi_a_q, hi_b_q;
    logic [LSLOTS-1:0][BEXT-1:0]     lo_a, lo_b, lo_a_q, lo_b_q;
    logic [HSLOTS-1:0][2*HALF_W-1:0] hi_p;
    logic [LSLOTS-1:0][2*BYTE_W-1:0] lo_p;

    // Purpose: decode the control word and qualify the issue handshake.
    always_comb begin
        ctrl     = vwm_ctrl_t'(op_ctrl);
        fire     = in_valid & ready_q;
        in_ready = ready_q;
    end

    vwm_operand_pick #(.VEC_W(VEC_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_pick (
        .ctrl(ctrl), .src_a(src_a), .src_b(src_b),
        .hi_a(hi_a), .hi_b(hi_b), .lo_a(lo_a), .lo_b(lo_b)
    );

    // Purpose: the valid chain and the ready flag, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            v1_q    <= 1'b0;
            v2_q    <= 1'b0;
        end else begin
            ready_q <= 1'b1;
            v1_q    <= fire;
            v2_q    <= v1_q;
        end
    end

    // Purpose: capture the operands and element size at issue, so later inputs cannot disturb them.
    always_ff @(posedge clk) begin
        if (fire) begin
            hi_a_q  <= hi_a;
            hi_b_q  <= hi_b;
            lo_a_q  <= lo_a;
            lo_b_q  <= lo_b;
            byte1_q <= ctrl.is_byte;
        end
        if (v1_q) byte2_q <= byte1_q;
    end

    for (genvar g = 0; g < HSLOTS; g++) begin : g_hmul
        vwm_lane_mult #(.OP_W(HEXT)) u_mul (
            .clk(clk), .rst_n(rst_n), .adv(v1_q),
            .op_a(hi_a_q[g]), .op_b(hi_b_q[g]), .prod_q(hi_p[g])
        );
    end

    for (genvar g = 0; g < LSLOTS; g++) begin : g_lmul
        vwm_lane_mult #(.OP_W(BEXT)) u_mul (
            .clk(clk), .rst_n(rst_n), .adv(v1_q),
            .op_a(lo_a_q[g]), .op_b(lo_b_q[g]), .prod_q(lo_p[g])
        );
    end

    vwm_result_pack #(.VEC_W(VEC_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_pack (
        .is_byte(byte2_q), .hi_p(hi_p), .lo_p(lo_p), .result(out_result)
    );

    assign out_valid = v2_q;

    // R7: a result appears exactly two edges after each accepted issue, and at no other time.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(fire, 2));

    // R9: an edge with reset asserted leaves the unit idle and not ready.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !in_ready));

    // R10: once reset has been released for a full cycle, the unit is always ready.
    assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

// File: tb/sim_vec_widen_mul.sv
// Bench: the driver pushes reference results into a scoreboard queue, and a monitor
// pops and compares them whenever out_valid is seen at a falling edge.
module sim_vec_widen_mul;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   op_ctrl = 3'b000;
    logic [127:0] src_a = '0, src_b = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [127:0] exp;
        int           at;
        string        tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_widen_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_ctrl(op_ctrl), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference: computes each lane independently, in 64-bit integer arithmetic.
    function automatic logic [127:0] ref_mul(input logic [2:0] c, input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        longint va, vb, pr;
        int lane;
        logic [15:0] ha, hb;
        logic [7:0] ba, bb;
        r = '0;
        if (c[0]) begin
            for (int i = 0; i < 8; i++) begin
                lane = 2 * i + int'(c[2]);
                ba = a[127-8*lane -: 8];
                bb = b[127-8*lane -: 8];
                va = c[1] ? longint'({56'b0, ba}) : longint'($signed(ba));
                vb = c[1] ? longint'({56'b0, bb}) : longint'($signed(bb));
                pr = va * vb;
                r[127-16*i -: 16] = pr[15:0];
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                lane = 2 * i + int'(c[2]);
                ha = a[127-16*lane -: 16];
                hb = b[127-16*lane -: 16];
                va = c[1] ? longint'({48'b0, ha}) : longint'($signed(ha));
                vb = c[1] ? longint'({48'b0, hb}) : longint'($signed(hb));
                pr = va * vb;
                r[127-32*i -: 32] = pr[31:0];
            end
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Driver: offer one operation for one cycle (entered at a falling edge).
    task automatic issue(input logic [2:0] c, input logic [127:0] a, input logic [127:0] b, input string tag);
        item_t it;
        in_valid = 1'b1;
        op_ctrl  = c;
        src_a    = a;
        src_b    = b;
        it.exp   = ref_mul(c, a, b);
        it.at    = cyc;
        it.tag   = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Idle cycle with random garbage on the operand bus (R8).
    task automatic idle();
        in_valid = 1'b0;
        op_ctrl  = 3'($urandom());
        src_a    = rnd128();
        src_b    = rnd128();
        @(negedge clk);
    endtask

    // Monitor: compare each result against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 spurious out_valid", out_result, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(out_result === it.exp, it.tag, out_result, it.exp);
                chk(cyc - it.at == 2, "R7 latency", 128'(cyc - it.at), 128'd2);
            end
        end
    end

    function automatic logic [127:0] f16(input logic [15:0] x); return {8{x}}; endfunction
    function automatic logic [127:0] f8(input logic [7:0] x); return {16{x}}; endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=finished", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        // R9: reset holds the unit idle, and an offered operation is ignored.
        in_valid = 1'b1;
        src_a = f16(16'h1234);
        src_b = f16(16'h5678);
        repeat (4) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 out_valid in reset", 128'(out_valid), 128'd0);
            chk(in_ready == 1'b0, "R9 in_ready in reset", 128'(in_ready), 128'd0);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 ready after reset", 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R9 no result from reset-time offer", 128'(out_valid), 128'd0);

        // R1: even halfword lanes, distinct values per lane.
        a = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
        b = 128'h0010_0020_0030_0040_0050_0060_0070_0080;
        issue(3'b000, a, b, "R1 even signed distinct");
        issue(3'b010, a, b, "R1 even unsigned distinct");
        issue(3'b000, f16(16'h0000), rnd128(), "R1 zero operand");
        // R2: odd lanes.
        issue(3'b100, a, b, "R2 odd signed distinct");
        issue(3'b110, a, b, "R2 odd unsigned distinct");
        // R3: signed extremes, even and odd.
        issue(3'b000, f16(16'h8000), f16(16'h8000), "R3 min*min even");
        issue(3'b100, f16(16'h8000), f16(16'h8000), "R3 min*min odd");
        issue(3'b000, f16(16'h7FFF), f16(16'h8000), "R3 max*min");
        issue(3'b100, f16(16'h7FFF), f16(16'h7FFF), "R3 max*max");
        issue(3'b000, f16(16'hFFFF), f16(16'h7FFF), "R3 -1*max");
        // R4: unsigned extremes.
        issue(3'b010, f16(16'hFFFF), f16(16'hFFFF), "R4 umax*umax even");
        issue(3'b110, f16(16'hFFFF), f16(16'h8000), "R4 umax*0x8000 odd");
        // R5: byte modes, all four combinations.
        issue(3'b001, f8(8'h80), f8(8'h80), "R5 byte signed min*min");
        issue(3'b101, f8(8'h7F), f8(8'h80), "R5 byte signed odd max*min");
        issue(3'b011, f8(8'hFF), f8(8'hFF), "R5 byte unsigned umax");
        issue(3'b111, f8(8'hFF), f8(8'h7F), "R5 byte unsigned odd");
        issue(3'b001, 128'h01_02_03_04_05_06_07_08_09_0A_0B_0C_0D_0E_0F_10,
                      128'hF0_E0_D0_C0_B0_A0_90_80_70_60_50_40_30_20_10_00, "R5 byte distinct");
        // R6: the same selected lanes with different unselected lanes give the same result.
        issue(3'b000, 128'h1111_AAAA_2222_BBBB_3333_CCCC_4444_DDDD, f16(16'h0003), "R6 even, odd lanes A");
        issue(3'b000, 128'h1111_5555_2222_6666_3333_7777_4444_8888, f16(16'h0003), "R6 even, odd lanes B");
        issue(3'b101, 128'hAA01_BB02_CC03_DD04_EE05_FF06_1107_2208, f8(8'hFF), "R6 byte odd, even lanes varied");
        // R8: issues separated by idle cycles that carry garbage operands.
        for (int k = 0; k < 30; k++) begin
            issue(3'($urandom()), rnd128(), rnd128(), "R8 capture at issue");
            repeat (1 + k % 3) idle();
        end
        // R10: back-to-back random operations in every mode.
        for (int k = 0; k < 300; k++)
            issue(3'($urandom()), rnd128(), rnd128(), "R10 back-to-back");
        repeat (4) idle();
        chk(sb.size() == 0, "R7 all results delivered", 128'(sb.size()), 128'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule